// File: doc/BRIEF.md
# Swap-Steered Two-Operand ALU Slice

This block is the arithmetic and logic datapath slice used by two-operand instructions. Both operands pass through an inbound byte-exchange stage, feed a combinational ALU that computes the new destination value from a source operand A and a destination operand B, and then pass through an outbound byte-exchange stage before the result is registered. Each exchange stage is a row of two-input multiplexers. It either passes the word unchanged or trades its upper and lower halves, and it takes no extra clock cycle.

Byte instructions use the same ALU. The control sequencer sets the exchange controls so that the operand byte sits in the upper half during the operation. The ALU then works on that upper half, and the untouched lower half of the destination rides along so that a read-modify-write puts it back unchanged. A byte-swap instruction is a move with the inbound exchange enabled.

The block runs under a two-state controller. In `ST_IDLE`, a `start` strobe takes the transition `GO` to `ST_DONE`. At that edge the result, the write-enable and the status flags are captured. In `ST_DONE`, another `start` takes `AGAIN`, which stays in `ST_DONE` for back-to-back operations. Without a strobe, the transition `REST` returns the controller to `ST_IDLE`.

Top module: `alu_swap_path`

## Requirements
- R1: While reset is held and right after it is released, `result` is zero, all five status flags are zero, and `done` and `wr_en` are low.
- R2: `done` is high in the cycle after every cycle in which `start` is high and low in the cycle after every cycle in which `start` is low, so back-to-back strobes keep it high.
- R3: Op code 3'b111 yields B OR A, 3'b110 yields A, 3'b101 yields B + A, 3'b011 yields A − B and 3'b010 yields B AND NOT A. The value is computed on the operands after the inbound stage.
- R4: Op code 3'b100 (compare) computes A − B for the flags only. `wr_en` stays low and `result` keeps its previous value.
- R5: Op codes 3'b000 and 3'b001 are reserved. They leave `result` and all five flags unchanged and keep `wr_en` low, but `done` still follows R2.
- R6: When `swap_in` is 1, both operands have bits [15:8] and [7:0] exchanged before the ALU. When `swap_out` is 1, the outgoing word is exchanged the same way. A move with `swap_in`=1 returns A with its bytes exchanged.
- R7: With `byte_mode`=1, the ALU and flags use bits [15:8] of the inbound operands only. The result's bits [7:0], before the outbound stage, are bits [7:0] of the inbound B.
- R8: For ops 010, 011, 101, 110 and 111, `st_lgt` means the active-width result is nonzero, `st_agt` means it is positive as a signed value, and `st_eq` means it is zero.
- R9: For compare, `st_lgt` means A > B unsigned, `st_agt` means A > B signed, and `st_eq` means A equals B, over the active width.
- R10: Add sets `st_c` to the carry out and `st_ov` to signed overflow. Subtract and compare set `st_c` to 1 when A ≥ B unsigned (no borrow) and `st_ov` to signed overflow of A − B. Ops 010, 110 and 111 leave `st_c` and `st_ov` unchanged.
- R11: `wr_en` is high exactly in the cycle after a strobe carrying op 010, 011, 101, 110 or 111, and only while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation strobe; inputs are sampled with it |
| op | input | 3 | ALU operation code |
| byte_mode | input | 1 | 1 = operate on the upper byte only |
| swap_in | input | 1 | Exchange operand bytes before the ALU |
| swap_out | input | 1 | Exchange result bytes after the ALU |
| a_val | input | 16 | Source operand A |
| b_val | input | 16 | Destination operand B |
| result | output | 16 | Registered destination value |
| wr_en | output | 1 | Destination write enable, one cycle |
| done | output | 1 | Result and flags updated this cycle |
| st_lgt | output | 1 | Logical (unsigned) greater flag |
| st_agt | output | 1 | Arithmetic (signed) greater flag |
| st_eq | output | 1 | Equal flag |
| st_c | output | 1 | Carry flag |
| st_ov | output | 1 | Overflow flag |

## Verification
The bench builds the block with its default 16-bit datapath, so the byte half is 8 bits. This puts the 8-bit carry and overflow boundaries (0x7F+0x01, 0xFF+0x01) within reach alongside the 16-bit ones. Swap-in and swap-out combinations that rebuild a lower-byte destination can be checked bit by bit against the preserved upper byte. Table vectors and random operations cover all eight op codes in both modes, back-to-back strobes and a reset in mid-run.

// File: rtl/alu_swap_pkg.sv
package alu_swap_pkg;

    typedef enum logic [2:0] {
        OP_RSV0    = 3'b000,
        OP_RSV1    = 3'b001,
        OP_CLRBITS = 3'b010,
        OP_SUB     = 3'b011,
        OP_CMP     = 3'b100,
        OP_ADD     = 3'b101,
        OP_MOVE    = 3'b110,
        OP_SETBITS = 3'b111
    } alu_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic lgt;
        logic agt;
        logic eq;
        logic c;
        logic ov;
    } status_t;

endpackage

// File: rtl/byte_swap.sv
module byte_swap #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    input  logic         swap,
    output logic [W-1:0] dout
);
    localparam int HALF = W / 2;

    for (genvar i = 0; i < W; i++) begin : g_mux
        assign dout[i] = swap ? din[(i + HALF) % W] : din[i];
    end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
    import alu_swap_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         ovf,
    output logic         lgt,
    output logic         agt,
    output logic         eq
);
    logic [W:0] sum;
    logic [W:0] dif;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        dif = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
        unique case (op)
            OP_SETBITS: res = b | a;
            OP_MOVE:    res = a;
            OP_ADD:     res = sum[W-1:0];
            OP_CMP:     res = dif[W-1:0];
            OP_SUB:     res = dif[W-1:0];
            OP_CLRBITS: res = b & ~a;
            OP_RSV0:    res = b;
            OP_RSV1:    res = b;
        endcase

        if (op == OP_ADD) begin
            carry = sum[W];
            ovf   = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
        end else begin
            carry = dif[W];
            ovf   = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
        end

        if (op == OP_CMP) begin
            lgt = a > b;
            agt = $signed(a) > $signed(b);
            eq  = a == b;
        end else begin
            lgt = |res;
            agt = !res[W-1] && (|res);
            eq  = ~|res;
        end
    end

endmodule

// File: rtl/alu_swap_path.sv
module alu_swap_path
    import alu_swap_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic              byte_mode,
    input  logic              swap_in,
    input  logic              swap_out,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] b_val,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              done,
    output logic              st_lgt,
    output logic              st_agt,
    output logic              st_eq,
    output logic              st_c,
    output logic              st_ov
);
    localparam int HALF_W = DATA_W / 2;

    seq_state_e state_q, state_d;
    alu_op_e    op_e;

    logic [DATA_W-1:0] a_sw, b_sw, word_res, merged, out_word, result_q;
    logic [HALF_W-1:0] byte_res;
    logic w_c, w_ov, w_lgt, w_agt, w_eq;
    logic h_c, h_ov, h_lgt, h_agt, h_eq;
    logic writes_op, arith_op, valid_op, wr_q;
    status_t st_new, st_q;

    assign op_e = alu_op_e'(op);

    byte_swap #(.W(DATA_W)) u_swap_a   (.din(a_val),  .swap(swap_in),  .dout(a_sw));
    byte_swap #(.W(DATA_W)) u_swap_b   (.din(b_val),  .swap(swap_in),  .dout(b_sw));
    byte_swap #(.W(DATA_W)) u_swap_out (.din(merged), .swap(swap_out), .dout(out_word));

    alu_slice #(.W(DATA_W)) u_word_alu (
        .a(a_sw), .b(b_sw), .op(op_e), .res(word_res),
        .carry(w_c), .ovf(w_ov), .lgt(w_lgt), .agt(w_agt), .eq(w_eq)
    );

    alu_slice #(.W(HALF_W)) u_byte_alu (
        .a(a_sw[DATA_W-1:HALF_W]), .b(b_sw[DATA_W-1:HALF_W]), .op(op_e),
        .res(byte_res), .carry(h_c), .ovf(h_ov), .lgt(h_lgt), .agt(h_agt), .eq(h_eq)
    );

    always_comb begin
        if (byte_mode) begin
            merged = {byte_res, b_sw[HALF_W-1:0]};
            st_new = '{lgt: h_lgt, agt: h_agt, eq: h_eq, c: h_c, ov: h_ov};
        end else begin
            merged = word_res;
            st_new = '{lgt: w_lgt, agt: w_agt, eq: w_eq, c: w_c, ov: w_ov};
        end
        writes_op = (op_e == OP_SETBITS) || (op_e == OP_MOVE) || (op_e == OP_ADD) ||
                    (op_e == OP_SUB) || (op_e == OP_CLRBITS);
        arith_op  = (op_e == OP_ADD) || (op_e == OP_SUB) || (op_e == OP_CMP);
        valid_op  = writes_op || (op_e == OP_CMP);
    end

    // next-state logic: GO, AGAIN, REST
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            st_q     <= '0;
            wr_q     <= 1'b0;
        end else begin
            wr_q <= start && writes_op;
            if (start && valid_op) begin
                st_q.lgt <= st_new.lgt;
                st_q.agt <= st_new.agt;
                st_q.eq  <= st_new.eq;
                if (arith_op) begin
                    st_q.c  <= st_new.c;
                    st_q.ov <= st_new.ov;
                end
                if (writes_op) result_q <= out_word;
            end
        end
    end

    always_comb begin
        done   = (state_q == ST_DONE);
        wr_en  = wr_q;
        result = result_q;
        st_lgt = st_q.lgt;
        st_agt = st_q.agt;
        st_eq  = st_q.eq;
        st_c   = st_q.c;
        st_ov  = st_q.ov;
    end

    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_idle_without_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'b100) |=> (!wr_en && $stable(result)));

    assert_reserved_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op[2:1] == 2'b00) |=> ($stable(result) && $stable(st_c) && $stable(st_ov)
                                         && $stable(st_eq) && $stable(st_lgt) && $stable(st_agt)));

    assert_byte_low_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && byte_mode && !swap_in && !swap_out && (op[2] || op[1]) && op != 3'b100)
        |=> (result[HALF_W-1:0] == $past(b_val[HALF_W-1:0])));

    assert_eq_excludes_gt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_eq |-> (!st_lgt && !st_agt));

    assert_logic_keeps_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (op == 3'b111 || op == 3'b110 || op == 3'b010)) |=> ($stable(st_c) && $stable(st_ov)));

    assert_write_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

endmodule

// File: tb/alu_swap_path_test.sv
module alu_swap_path_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b000;
    logic        byte_mode = 1'b0, swap_in = 1'b0, swap_out = 1'b0;
    logic [15:0] a_val = '0, b_val = '0;
    logic [15:0] result;
    logic        wr_en, done, st_lgt, st_agt, st_eq, st_c, st_ov;

    int checks = 0;
    int errors = 0;

    // expected state held by the bench model
    logic [15:0] e_res = '0;
    logic e_wr = 0, e_lgt = 0, e_agt = 0, e_eq = 0, e_c = 0, e_ov = 0;

    alu_swap_path #(.DATA_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .byte_mode(byte_mode),
        .swap_in(swap_in), .swap_out(swap_out), .a_val(a_val), .b_val(b_val),
        .result(result), .wr_en(wr_en), .done(done), .st_lgt(st_lgt), .st_agt(st_agt),
        .st_eq(st_eq), .st_c(st_c), .st_ov(st_ov)
    );

    always #2 clk = ~clk;

    // {op, byte_mode, swap_in, swap_out, a, b}
    localparam int NVEC = 16;
    localparam logic [37:0] VEC [0:NVEC-1] = '{
        {3'b101, 1'b0, 1'b0, 1'b0, 16'h7FFF, 16'h0001},
        {3'b101, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0001},
        {3'b011, 1'b0, 1'b0, 1'b0, 16'h0005, 16'h0007},
        {3'b011, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h0001},
        {3'b100, 1'b0, 1'b0, 1'b0, 16'h0003, 16'h0003},
        {3'b100, 1'b0, 1'b0, 1'b0, 16'h8000, 16'h0001},
        {3'b111, 1'b0, 1'b0, 1'b0, 16'h00F0, 16'h0F00},
        {3'b110, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hBEEF},
        {3'b010, 1'b0, 1'b0, 1'b0, 16'h00FF, 16'h1234},
        {3'b110, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0000},
        {3'b101, 1'b1, 1'b0, 1'b0, 16'h7F00, 16'h0155},
        {3'b101, 1'b1, 1'b1, 1'b1, 16'h0012, 16'hAB34},
        {3'b100, 1'b1, 1'b0, 1'b0, 16'hFF00, 16'h0100},
        {3'b011, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0200},
        {3'b000, 1'b0, 1'b0, 1'b0, 16'hAAAA, 16'h5555},
        {3'b110, 1'b1, 1'b0, 1'b0, 16'h8000, 16'h1234}
    };

    function automatic logic [15:0] xchg(input logic [15:0] v);
        return {v[7:0], v[15:8]};
    endfunction

    function automatic string req_of(input logic [2:0] o, input logic bm, input logic si, input logic so);
        if (o[2:1] == 2'b00)         return "R5";
        if (bm)                      return "R7 R10";
        if (si || so)                return "R6";
        if (o == 3'b100)             return "R4 R9";
        if (o == 3'b101 || o == 3'b011) return "R3 R10 R11";
        return "R3 R8 R11";
    endfunction

    // behavioural model derived from the requirements
    task automatic model(input logic [2:0] o, input logic bm, input logic si, input logic so,
                         input logic [15:0] a, input logic [15:0] b);
        logic [15:0] ai, bi, w;
        int mask, wd, x, y, r, sx, sy;
        ai = si ? xchg(a) : a;
        bi = si ? xchg(b) : b;
        wd   = bm ? 8 : 16;
        mask = bm ? 32'hFF : 32'hFFFF;
        x = bm ? int'(ai[15:8]) : int'(ai);
        y = bm ? int'(bi[15:8]) : int'(bi);
        e_wr = 1'b0;
        if (o[2:1] == 2'b00) return;
        case (o)
            3'b111: r = x | y;
            3'b110: r = x;
            3'b101: r = (x + y) & mask;
            3'b010: r = y & ~x & mask;
            default: r = (x - y) & mask;
        endcase
        sx = ((x >> (wd - 1)) & 1) != 0 ? x - (mask + 1) : x;
        sy = ((y >> (wd - 1)) & 1) != 0 ? y - (mask + 1) : y;
        if (o == 3'b100) begin
            e_lgt = x > y;
            e_agt = sx > sy;
            e_eq  = x == y;
        end else begin
            e_lgt = r != 0;
            e_agt = (r != 0) && (((r >> (wd - 1)) & 1) == 0);
            e_eq  = r == 0;
        end
        if (o == 3'b101) begin
            e_c  = (x + y) > mask;
            e_ov = (((x ^ y) >> (wd - 1)) & 1) == 0 && (((x ^ r) >> (wd - 1)) & 1) == 1;
        end else if (o == 3'b011 || o == 3'b100) begin
            e_c  = x >= y;
            e_ov = (((x ^ y) >> (wd - 1)) & 1) == 1 && (((x ^ r) >> (wd - 1)) & 1) == 1;
        end
        if (o != 3'b100) begin
            w = bm ? {r[7:0], bi[7:0]} : r[15:0];
            e_res = so ? xchg(w) : w;
            e_wr  = 1'b1;
        end
    endtask

    task automatic check(input string tag, input logic exp_done);
        logic [22:0] got, exp;
        got = {result, wr_en, done, st_lgt, st_agt, st_eq, st_c, st_ov};
        exp = {e_res, e_wr, exp_done, e_lgt, e_agt, e_eq, e_c, e_ov};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    // drives one strobe; start is left high for the caller to drop
    task automatic issue(input logic [2:0] o, input logic bm, input logic si, input logic so,
                         input logic [15:0] a, input logic [15:0] b);
        op = o; byte_mode = bm; swap_in = si; swap_out = so; a_val = a; b_val = b;
        start = 1'b1;
        model(o, bm, si, so, a, b);
        @(negedge clk);
        check(req_of(o, bm, si, so), 1'b1);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got hang exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        // table walk, strobes back to back (R2)
        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i][37:35], VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);
        end
        start = 1'b0;
        e_wr = 1'b0;
        @(negedge clk);
        check("R2", 1'b0);

        // byte swap as move with inbound swap (R6)
        issue(3'b110, 1'b0, 1'b1, 1'b0, 16'hA1B2, 16'hFFFF);
        start = 1'b0; e_wr = 1'b0;
        @(negedge clk);
        check("R6", 1'b0);

        // lower-byte destination kept by swap in/out, byte add 0xFF+0x01 (R7, R10)
        issue(3'b101, 1'b1, 1'b1, 1'b1, 16'h00FF, 16'h5A01);
        // compare leaves result after a write (R4)
        issue(3'b100, 1'b0, 1'b0, 1'b0, 16'h0001, 16'h0002);
        // logical op keeps carry/overflow from compare (R10)
        issue(3'b111, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000);
        // reserved op 001 (R5)
        issue(3'b001, 1'b1, 1'b1, 1'b1, 16'h1111, 16'h2222);
        start = 1'b0; e_wr = 1'b0;
        @(negedge clk);
        check("R2 R11", 1'b0);

        // random mix of every op in both modes
        for (int k = 0; k < 400; k++) begin
            issue(3'($urandom % 8), 1'($urandom), 1'($urandom), 1'($urandom),
                  16'($urandom), 16'($urandom));
            if (($urandom % 3) == 0) begin
                start = 1'b0; e_wr = 1'b0;
                @(negedge clk);
                check("R2", 1'b0);
            end
        end
        start = 1'b0;

        // reset in mid-run (R1)
        issue(3'b101, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFF);
        start = 1'b0;
        rst_n = 1'b0;
        e_res = '0; e_wr = 0; e_lgt = 0; e_agt = 0; e_eq = 0; e_c = 0; e_ov = 0;
        @(negedge clk);
        check("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule